// File: doc/BRIEF.md
# Cache Set/Way Clean Sequencer

This block walks the levels of a cache hierarchy in hardware and produces one clean-by-set/way operand for every line of every level that holds data. Software, or a power controller, gives it a start pulse together with the level identification word and a bound on the number of levels to visit. The sequencer reads the per-level type fields and passes over levels that hold no cache or only an instruction cache. For each level it does keep, it drives a select output. It waits one settling cycle, then latches that level's size identification word and derives three things from it: the line-length shift, the highest way number and the highest set number.

It then counts the ways down inside the sets, and the sets down inside the level. For each step it presents a 32-bit operand on a valid/ready output. The operand carries the level number in bits [3:1]. The way number is aligned to the top of the word by a leading-zero count of the highest way number. The set number sits at the line-length shift. A one-cycle done pulse marks the end of the walk.

Top module: `cache_sw_walker`

## Requirements
- R1: After reset, op_valid_o, done_o and busy_o are low and sel_o is 0.
- R2: The type of level n is level_id_i[3n+2:3n]. Type 0 means no cache, 1 instruction-only, 2 data, 3 split and 4 unified. A level whose type is below 2 produces no operand.
- R3: Levels are visited in ascending order from 0 up to loc_i-1. sel_o carries the visited level in bits [3:1] and holds 0 in bit 0.
- R4: size_id_i is sampled at the second rising edge after sel_o takes the new level. It therefore only has to be correct from the cycle after the select changes.
- R5: The line shift is size_id_i[2:0]+4. The set number is placed at bit position line shift.
- R6: The highest way number is size_id_i[12:3] and the highest set number is size_id_i[27:13]. Ways count down inside each set and sets count down, both inclusive of 0. A level therefore yields (ways+1)*(sets+1) operands.
- R7: The way field is shifted left by the leading-zero count of the 32-bit highest way number. When the highest way number is 0, the way field contributes nothing.
- R8: The operand is the OR of level*2, the shifted way field and the shifted set number.
- R9: While op_valid_o is high and op_ready_i is low, op_valid_o stays high and op_data_o stays unchanged.
- R10: done_o is high for exactly one cycle. It rises two cycles after the last operand is accepted when no later level is checked, and it rises (2 + number of levels checked) cycles after start when no level qualifies.
- R11: busy_o is high from the cycle after an accepted start until done_o has been shown. A start pulse received while busy_o is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk when idle |
| level_id_i | input | 32 | Per-level 3-bit type fields |
| loc_i | input | 3 | Number of levels to visit |
| sel_o | output | 4 | Selected level times two |
| size_id_i | input | 32 | Size identification word of the selected level |
| op_valid_o | output | 1 | Operand valid |
| op_ready_i | input | 1 | Operand accepted when high with valid |
| op_data_o | output | 32 | Packed level/way/set operand |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |

## Verification
The hardest case to reach from the ports is a size word read too early. It only shows when the select changes from one level to another whose geometry differs. To reach it, the bench models the size register with one cycle of latency behind sel_o. It then places data levels right after skipped levels whose size words hold deliberately different geometry, so a missing settling cycle yields wrongly shifted operands. Back-pressure is applied with a periodic ready pattern, and a second start is injected in the middle of a walk.

// File: rtl/sw_pkg.sv
package sw_pkg;

    localparam int WORD_W    = 32;
    localparam int LVL_W     = 3;
    localparam int TYPE_W    = 3;
    localparam int LS_W      = 3;
    localparam int WAY_W     = 10;
    localparam int SET_W     = 15;
    localparam int WAY_LSB   = LS_W;
    localparam int SET_LSB   = WAY_LSB + WAY_W;
    localparam int SH_W      = $clog2(WORD_W) + 1;
    localparam int LINE_BASE = 4;
    localparam int MIN_DTYPE = 2;
    localparam int SEL_W     = LVL_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SETTLE,
        ST_EMIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic [SH_W-1:0]  line_sh;
        logic [WAY_W-1:0] max_way;
        logic [SET_W-1:0] max_set;
        logic [SH_W-1:0]  way_sh;
        logic             way_none;
    } geom_t;

    function automatic logic [SH_W-1:0] lead_zeros(input logic [WORD_W-1:0] v);
        logic [SH_W-1:0] n;
        logic            hit;
        n   = SH_W'(WORD_W);
        hit = 1'b0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (!hit && v[i]) begin
                n   = SH_W'(WORD_W - 1 - i);
                hit = 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic [TYPE_W-1:0] level_type(input logic [WORD_W-1:0] id,
                                                     input logic [LVL_W-1:0]  lvl);
        logic [WORD_W-1:0] sh;
        sh = id >> (TYPE_W * int'(lvl));
        return sh[TYPE_W-1:0];
    endfunction

endpackage

// File: rtl/sw_geom_decode.sv
module sw_geom_decode
    import sw_pkg::*;
(
    input  logic [WORD_W-1:0] size_id_i,
    output geom_t             geom_o
);
    logic [WAY_W-1:0] max_way;

    assign max_way = size_id_i[WAY_LSB +: WAY_W];

    always_comb begin
        geom_o.line_sh  = SH_W'(size_id_i[LS_W-1:0]) + SH_W'(LINE_BASE);
        geom_o.max_way  = max_way;
        geom_o.max_set  = size_id_i[SET_LSB +: SET_W];
        geom_o.way_sh   = lead_zeros(WORD_W'(max_way));
        geom_o.way_none = (max_way == '0);
    end
endmodule

// File: rtl/sw_index_walker.sv
module sw_index_walker
    import sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WAY_W-1:0] max_way_i,
    input  logic [SET_W-1:0] max_set_i,
    input  logic             step_i,
    output logic [WAY_W-1:0] way_o,
    output logic [SET_W-1:0] set_o,
    output logic             last_o
);
    logic [WAY_W-1:0] top_way_q;
    logic [WAY_W-1:0] way_q;
    logic [SET_W-1:0] set_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_way_q <= '0;
            way_q     <= '0;
            set_q     <= '0;
        end else if (load_i) begin
            top_way_q <= max_way_i;
            way_q     <= max_way_i;
            set_q     <= max_set_i;
        end else if (step_i) begin
            if (way_q == '0) begin
                if (set_q != '0) begin
                    set_q <= set_q - 1'b1;
                    way_q <= top_way_q;
                end
            end else begin
                way_q <= way_q - 1'b1;
            end
        end
    end

    assign way_o  = way_q;
    assign set_o  = set_q;
    assign last_o = (way_q == '0) && (set_q == '0);
endmodule

// File: rtl/sw_operand_pack.sv
module sw_operand_pack
    import sw_pkg::*;
(
    input  logic [LVL_W-1:0]  level_i,
    input  logic [WAY_W-1:0]  way_i,
    input  logic [SET_W-1:0]  set_i,
    input  geom_t             geom_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] lvl_part;
    logic [WORD_W-1:0] way_part;
    logic [WORD_W-1:0] set_part;

    always_comb begin
        lvl_part = WORD_W'({level_i, 1'b0});
        way_part = geom_i.way_none ? '0 : (WORD_W'(way_i) << geom_i.way_sh);
        set_part = WORD_W'(set_i) << geom_i.line_sh;
        word_o   = lvl_part | way_part | set_part;
    end
endmodule

// File: rtl/cache_sw_walker.sv
module cache_sw_walker
    import sw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] level_id_i,
    input  logic [LVL_W-1:0]  loc_i,
    output logic [SEL_W-1:0]  sel_o,
    input  logic [WORD_W-1:0] size_id_i,
    output logic              op_valid_o,
    input  logic              op_ready_i,
    output logic [WORD_W-1:0] op_data_o,
    output logic              busy_o,
    output logic              done_o
);
    walk_state_e      state_q;
    logic [LVL_W-1:0] level_q;
    geom_t            geom_d;
    geom_t            geom_q;
    logic [WAY_W-1:0] way;
    logic [SET_W-1:0] set_idx;
    logic             last;
    logic             level_in_range;
    logic             level_has_data;
    logic             accept;
    logic             load;

    assign level_in_range = (level_q < loc_i);
    assign level_has_data = (level_type(level_id_i, level_q) >= TYPE_W'(MIN_DTYPE));
    assign accept         = (state_q == ST_EMIT) && op_ready_i;
    assign load           = (state_q == ST_SETTLE);

    sw_geom_decode u_decode (
        .size_id_i (size_id_i),
        .geom_o    (geom_d)
    );

    sw_index_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .max_way_i (geom_d.max_way),
        .max_set_i (geom_d.max_set),
        .step_i    (accept),
        .way_o     (way),
        .set_o     (set_idx),
        .last_o    (last)
    );

    sw_operand_pack u_pack (
        .level_i (level_q),
        .way_i   (way),
        .set_i   (set_idx),
        .geom_i  (geom_q),
        .word_o  (op_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            geom_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        level_q <= '0;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!level_in_range) begin
                        state_q <= ST_DONE;
                    end else if (level_has_data) begin
                        state_q <= ST_SETTLE;
                    end else begin
                        level_q <= level_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    geom_q  <= geom_d;
                    state_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (op_ready_i && last) begin
                        level_q <= level_q + 1'b1;
                        state_q <= ST_CHECK;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sel_o      = {level_q, 1'b0};
    assign op_valid_o = (state_q == ST_EMIT);
    assign done_o     = (state_q == ST_DONE);
    assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/sw_walker_checker.sv
module sw_walker_checker
    import sw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [WORD_W-1:0] level_id_i,
    input logic [LVL_W-1:0]  loc_i,
    input logic [SEL_W-1:0]  sel_o,
    input logic [WORD_W-1:0] size_id_i,
    input logic              op_valid_o,
    input logic              op_ready_i,
    input logic [WORD_W-1:0] op_data_o,
    input logic              busy_o,
    input logic              done_o
);
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (op_valid_o && !op_ready_i) |=> (op_valid_o && $stable(op_data_o)));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_done_no_valid: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !op_valid_o);

    a_r8_level_bits: assert property (@(posedge clk) disable iff (rst)
        op_valid_o |-> (op_data_o[SEL_W-1:1] == sel_o[SEL_W-1:1]) && !op_data_o[0]);

    a_r2_data_level_only: assert property (@(posedge clk) disable iff (rst)
        op_valid_o |-> (level_type(level_id_i, sel_o[SEL_W-1:1]) >= TYPE_W'(MIN_DTYPE)));

    a_r3_within_bound: assert property (@(posedge clk) disable iff (rst)
        op_valid_o |-> (sel_o[SEL_W-1:1] < loc_i));

    a_r4_settle_gap: assert property (@(posedge clk) disable iff (rst)
        $changed(sel_o) |=> !op_valid_o);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!op_valid_o && !done_o));

    a_r11_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o);
endmodule

bind cache_sw_walker sw_walker_checker u_chk (.*);

// File: tb/sim_cache_sw_walker.sv
module sim_cache_sw_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WALK_LIMIT = 6000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] level_id_i = '0;
    logic [2:0]  loc_i = '0;
    logic [3:0]  sel_o;
    logic [31:0] size_id_i;
    logic        op_valid_o;
    logic        op_ready_i = 1'b0;
    logic [31:0] op_data_o;
    logic        busy_o;
    logic        done_o;

    logic [31:0] cfg [0:7];
    logic [3:0]  sel_d;

    int n_checks = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always_ff @(posedge clk) begin
        sel_d  <= sel_o;
        cycles <= cycles + 1;
    end

    assign size_id_i = cfg[sel_d[3:1]];

    cache_sw_walker u0 (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .level_id_i (level_id_i),
        .loc_i      (loc_i),
        .sel_o      (sel_o),
        .size_id_i  (size_id_i),
        .op_valid_o (op_valid_o),
        .op_ready_i (op_ready_i),
        .op_data_o  (op_data_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_size(input int ls, input int mw, input int ms);
        return (32'(ms) << 13) | (32'(mw) << 3) | 32'(ls);
    endfunction

    function automatic logic [31:0] exp_word(input int lvl, input int w, input int s, input int ls, input int mw);
        logic [31:0] wp;
        int hi;
        hi = -1;
        for (int b = 0; b < 32; b++) if (mw[b]) hi = b;
        wp = (hi < 0) ? 32'h0 : (32'(w) << (31 - hi));
        return 32'(lvl * 2) | wp | (32'(s) << (ls + 4));
    endfunction

    task automatic do_walk(input string name, input bit stall, input int restart_at, input int gap);
        logic [31:0] exq[$];
        logic [31:0] held_val;
        bit held;
        int idx, ndone, done_cyc, last_acc, cyc;
        exq = {};
        for (int l = 0; l < int'(loc_i); l++) begin
            int ty, ls, mw, ms;
            ty = int'((level_id_i >> (3 * l)) & 32'h7);
            if (ty < 2) continue;
            ls = int'(cfg[l][2:0]);
            mw = int'(cfg[l][12:3]);
            ms = int'(cfg[l][27:13]);
            for (int s = ms; s >= 0; s--)
                for (int w = mw; w >= 0; w--)
                    exq.push_back(exp_word(l, w, s, ls, mw));
        end
        idx = 0; ndone = 0; done_cyc = -1; last_acc = 0; held = 0; held_val = '0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        chk(busy_o, {name, " R11 busy after start"}, 32'(busy_o), 32'h1);
        while (cyc < WALK_LIMIT) begin
            bit rdy;
            rdy = !(stall && (cyc % 3 == 0));
            op_ready_i = rdy;
            start_i = (cyc == restart_at);
            if (held) begin
                chk(op_valid_o && op_data_o == held_val, {name, " R9 held operand"}, op_data_o, held_val);
                held = 0;
            end
            if (op_valid_o) begin
                if (rdy) begin
                    if (idx < exq.size())
                        chk(op_data_o == exq[idx], {name, " R8 operand"}, op_data_o, exq[idx]);
                    else
                        chk(1'b0, {name, " R6 extra operand"}, op_data_o, 32'h0);
                    idx++;
                    last_acc = cyc;
                end else begin
                    held = 1;
                    held_val = op_data_o;
                end
            end
            if (done_o) begin
                ndone++;
                if (done_cyc < 0) done_cyc = cyc;
            end
            if (done_cyc >= 0 && cyc > done_cyc + 2) break;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        op_ready_i = 1'b0;
        if (cyc >= WALK_LIMIT) chk(1'b0, {name, " R10 walk timed out"}, 32'(cyc), 32'(WALK_LIMIT));
        chk(idx == exq.size(), {name, " R6 operand count"}, 32'(idx), 32'(exq.size()));
        chk(ndone == 1, {name, " R10 one done pulse"}, 32'(ndone), 32'h1);
        if (gap >= 0)
            chk(done_cyc - last_acc == gap, {name, " R10 done timing"}, 32'(done_cyc - last_acc), 32'(gap));
        chk(!busy_o, {name, " R11 idle after done"}, 32'(busy_o), 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!op_valid_o, "R1 valid low", 32'(op_valid_o), 32'h0);
        chk(!done_o, "R1 done low", 32'(done_o), 32'h0);
        chk(!busy_o, "R1 busy low", 32'(busy_o), 32'h0);
        chk(sel_o == 4'h0, "R1 sel zero", 32'(sel_o), 32'h0);
    endtask

    task automatic t_single_level();
        // R5 R6 R7: data level 0, 4 ways, 8 sets, line shift 5
        for (int i = 0; i < 8; i++) cfg[i] = mk_size(6, 511, 3);
        cfg[0] = mk_size(1, 3, 7);
        level_id_i = 32'h2;
        loc_i = 3'd1;
        do_walk("single", 1'b0, -1, 2);
    endtask

    task automatic t_skip_levels();
        // R2 R3 R4: levels 0,1 skipped with different size words
        cfg[0] = mk_size(7, 1023, 100);
        cfg[1] = mk_size(0, 255, 50);
        cfg[2] = mk_size(2, 1, 2);
        cfg[3] = mk_size(7, 7, 1);
        cfg[4] = mk_size(3, 3, 3);
        level_id_i = (32'd3 << 9) | (32'd4 << 6) | (32'd0 << 3) | 32'd1;
        level_id_i |= (32'd2 << 12);
        loc_i = 3'd4;
        do_walk("skip", 1'b0, -1, 2);
    endtask

    task automatic t_direct_mapped();
        // R7: highest way 0 gives no way field
        cfg[0] = mk_size(0, 0, 5);
        cfg[1] = mk_size(4, 0, 2);
        level_id_i = (32'd4 << 3) | 32'd2;
        loc_i = 3'd2;
        do_walk("direct", 1'b0, -1, 2);
    endtask

    task automatic t_wide_ways();
        // R7: 1024 ways puts the way field at bit 22
        cfg[0] = mk_size(0, 1023, 0);
        level_id_i = 32'd3;
        loc_i = 3'd1;
        do_walk("wide", 1'b0, -1, 2);
    endtask

    task automatic t_backpressure();
        // R9: ready low every third cycle
        cfg[0] = mk_size(2, 2, 3);
        cfg[1] = mk_size(1, 1, 1);
        level_id_i = (32'd4 << 3) | 32'd2;
        loc_i = 3'd2;
        do_walk("stall", 1'b1, -1, 2);
    endtask

    task automatic t_no_level();
        // R10: nothing qualifies, done at 2 + levels checked
        level_id_i = 32'h0;
        loc_i = 3'd0;
        do_walk("empty", 1'b0, -1, 2);
        level_id_i = (32'd1 << 6) | (32'd0 << 3) | 32'd1;
        loc_i = 3'd3;
        do_walk("noncache", 1'b0, -1, 5);
    endtask

    task automatic t_restart_ignored();
        // R11: second start during the walk changes nothing
        cfg[0] = mk_size(3, 3, 3);
        level_id_i = 32'd2;
        loc_i = 3'd1;
        do_walk("restart", 1'b0, 6, 2);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) cfg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_level();
        t_skip_levels();
        t_direct_mapped();
        t_wide_ways();
        t_backpressure();
        t_no_level();
        t_restart_ignored();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule